// File: doc/BRIEF.md
# Device Interrupt Routing Controller

This block sits between a set of interrupt-raising devices and the processors of a chip. For every device it keeps a routing entry, which names a target CPU and an interrupt vector, and a control entry, which holds a mask flag and a pending flag. Software reaches both entries through a small register port with 64-bit registers. Each access is acknowledged one cycle after it is requested.

When a device line is raised and that device is unmasked, the block forwards the event. It emits a one-cycle post that carries the routed CPU id and vector, and in the same step it sets both the mask and the pending flag of that device. The device then stays silent until software clears pending and lowers the mask. Events that arrive while a device is masked are discarded. When several devices fire in the same cycle, the block posts one of them per cycle, starting with the lowest index. The other requests are held until their turn comes.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every device has mask=1, pending=0, target CPU 0 and vector 0. A routing read returns 0, a control read returns 0x4, and `reg_ack`, `reg_err` and `post_valid` are low.
- R2: The routing register of device i is at byte offset 8*i, where i occupies offset bits 7:3 and bit 8 is 0. A write stores the CPU id from data bits 12:8 and the vector from data bits 5:0. A read returns those fields in the same positions, with every other bit zero.
- R3: The control register of device i is at byte offset 0x100 + 8*i (offset bit 8 set). A read returns mask in bit 2 and pending in bit 0, with every other bit zero.
- R4: A control write loads mask from data bit 2. If data bit 1 is 1, the write clears pending. No write ever sets pending.
- R5: A device event that arrives while that device is masked produces no post and leaves its mask and pending unchanged.
- R6: A device event that arrives while that device is unmasked produces a post on the next cycle: `post_valid` high for exactly one cycle, with the routed CPU id and vector. On the same edge that device's mask and pending become 1.
- R7: When several unmasked devices have requests, one post is made per cycle in ascending device index. Requests that are not served stay held until their turn.
- R8: A held request whose device becomes masked before it is served is dropped without a post.
- R9: If a device is forwarded on the same edge as a control write to that device, the forward wins: mask=1 and pending=1 afterwards.
- R10: `reg_ack` rises exactly one cycle after `reg_req`. An offset is unmapped if bits 2:0 are not zero or if any offset bit above bit 8 is set. For an unmapped offset, `reg_err` is 1 alongside the ack, read data is zero, and a write changes no state. Write acks return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | NUM_DEV | One event line per device, sampled every cycle |
| reg_req | input | 1 | Register access request, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 64 | Write data |
| reg_ack | output | 1 | Access completed (one cycle after request) |
| reg_rdata | output | 64 | Read data, valid with `reg_ack` |
| reg_err | output | 1 | Access hit an unmapped offset, valid with `reg_ack` |
| post_valid | output | 1 | One-cycle interrupt post |
| post_cpu | output | CPU_W | Target CPU id of the post |
| post_vec | output | VEC_W | Interrupt vector of the post |

## Verification
The bench builds the block with its defaults: 32 devices, a full 5-bit CPU field, a full 6-bit vector field, a 12-bit offset and the loop-based picker. Because the fields are full width, an all-ones routing write shows whether the field boundaries at bits 12:8 and 5:0 are kept. The 12-bit offset leaves bits 11:9 above the map, so out-of-map offsets can be tried, and 32 devices let the bench drive both end indices, 0 and 31. A behavioural model is compared with the posts and register responses on every cycle. It is run alongside directed sequences that cover simultaneous firing, masking of a held request, and a control write that collides with a forward.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   localparam int REG_W       = 64;
   localparam int CPU_LSB     = 8;
   localparam int CPU_FIELD_W = 5;
   localparam int VEC_LSB     = 0;
   localparam int VEC_FIELD_W = 6;
   localparam int MASK_BIT    = 2;
   localparam int CLRP_BIT    = 1;
   localparam int PEND_BIT    = 0;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_ROUTE = 2'd1,
      ACC_CTRL  = 2'd2
   } acc_kind_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import irq_route_pkg::*;
#(
   parameter int NUM_DEV = 32,
   parameter int ADDR_W  = 12,
   localparam int IDX_W  = $clog2(NUM_DEV)
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind,
   output logic [IDX_W-1:0]  idx
);
   localparam int REGION_BIT = IDX_W + 3;

   logic aligned, upper_zero, in_range;

   assign aligned = (addr[2:0] == 3'b000);
   assign idx     = addr[REGION_BIT-1:3];

   if (ADDR_W > REGION_BIT + 1) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:REGION_BIT+1] == '0);
   end else begin : g_no_upper
      assign upper_zero = 1'b1;
   end

   if ((2 ** IDX_W) == NUM_DEV) begin : g_full_range
      assign in_range = 1'b1;
   end else begin : g_part_range
      assign in_range = (idx < IDX_W'(NUM_DEV));
   end

   always_comb begin
      if (!(aligned && upper_zero && in_range)) kind = ACC_NONE;
      else if (addr[REGION_BIT])                kind = ACC_CTRL;
      else                                      kind = ACC_ROUTE;
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N         = 32,
   parameter bit PICK_TWOS = 1'b0,
   localparam int IDX_W    = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   if (PICK_TWOS) begin : g_twos
      assign grant = req & (~req + {{(N-1){1'b0}}, 1'b1});
   end else begin : g_loop
      always_comb begin
         grant = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
               grant    = '0;
               grant[i] = 1'b1;
            end
         end
      end
   end

   assign any = |req;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) idx = idx | IDX_W'(i);
      end
   end

   assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~req) == '0));

   assert_grant_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (((grant - {{(N-1){1'b0}}, 1'b1}) & req) == '0) && (grant != '0));

endmodule

// File: rtl/irq_dev_slot.sv
module irq_dev_slot #(
   parameter int CPU_W = 5,
   parameter int VEC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             route_we,
   input  logic             ctrl_we,
   input  logic [CPU_W-1:0] cpu_d,
   input  logic [VEC_W-1:0] vec_d,
   input  logic             mask_d,
   input  logic             clrp_d,
   input  logic             fire_i,
   output logic [CPU_W-1:0] cpu_q,
   output logic [VEC_W-1:0] vec_q,
   output logic             mask_q,
   output logic             pend_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_q <= '0;
         vec_q <= '0;
      end else if (route_we) begin
         cpu_q <= cpu_d;
         vec_q <= vec_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b1;
         pend_q <= 1'b0;
      end else if (fire_i) begin
         mask_q <= 1'b1;
         pend_q <= 1'b1;
      end else if (ctrl_we) begin
         mask_q <= mask_d;
         if (clrp_d) pend_q <= 1'b0;
      end
   end

   assert_fire_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |-> !mask_q);

   assert_fire_sets_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> (mask_q && pend_q));

   assert_pend_only_by_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(fire_i));

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
   import irq_route_pkg::*;
#(
   parameter int NUM_DEV   = 32,
   parameter int CPU_W     = 5,
   parameter int VEC_W     = 6,
   parameter int ADDR_W    = 12,
   parameter bit PICK_TWOS = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DEV-1:0] dev_irq,
   input  logic               reg_req,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [63:0]        reg_wdata,
   output logic               reg_ack,
   output logic [63:0]        reg_rdata,
   output logic               reg_err,
   output logic               post_valid,
   output logic [CPU_W-1:0]   post_cpu,
   output logic [VEC_W-1:0]   post_vec
);
   localparam int IDX_W = $clog2(NUM_DEV);

   if (NUM_DEV < 2) begin : g_bad_ndev
      $error("NUM_DEV must be at least 2");
   end
   if (CPU_W < 1 || CPU_W > CPU_FIELD_W) begin : g_bad_cpu
      $error("CPU_W exceeds the CPU field");
   end
   if (VEC_W < 1 || VEC_W > VEC_FIELD_W) begin : g_bad_vec
      $error("VEC_W exceeds the vector field");
   end
   if (ADDR_W < IDX_W + 4) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   acc_kind_e          acc_kind;
   logic [IDX_W-1:0]   acc_idx;
   logic               wr_route_en, wr_ctrl_en;
   logic [NUM_DEV-1:0] mask_vec, pend_vec, grant_vec, req_q, arb_in;
   logic [CPU_W-1:0]   cpu_arr [NUM_DEV];
   logic [VEC_W-1:0]   vec_arr [NUM_DEV];
   logic               grant_any;
   logic [IDX_W-1:0]   grant_idx;
   logic [63:0]        rd_val;
   logic               unused_wdata;

   assign unused_wdata = ^reg_wdata;

   irq_reg_decode #(.NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W)) u_decode (
      .addr (reg_addr),
      .kind (acc_kind),
      .idx  (acc_idx)
   );

   assign wr_route_en = reg_req && reg_we && (acc_kind == ACC_ROUTE);
   assign wr_ctrl_en  = reg_req && reg_we && (acc_kind == ACC_CTRL);

   for (genvar g = 0; g < NUM_DEV; g++) begin : g_slot
      irq_dev_slot #(.CPU_W(CPU_W), .VEC_W(VEC_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .route_we (wr_route_en && (acc_idx == IDX_W'(g))),
         .ctrl_we  (wr_ctrl_en && (acc_idx == IDX_W'(g))),
         .cpu_d    (reg_wdata[CPU_LSB +: CPU_W]),
         .vec_d    (reg_wdata[VEC_LSB +: VEC_W]),
         .mask_d   (reg_wdata[MASK_BIT]),
         .clrp_d   (reg_wdata[CLRP_BIT]),
         .fire_i   (grant_vec[g]),
         .cpu_q    (cpu_arr[g]),
         .vec_q    (vec_arr[g]),
         .mask_q   (mask_vec[g]),
         .pend_q   (pend_vec[g])
      );
   end

   assign arb_in = (req_q | dev_irq) & ~mask_vec;

   irq_prio_pick #(.N(NUM_DEV), .PICK_TWOS(PICK_TWOS)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (arb_in),
      .grant (grant_vec),
      .any   (grant_any),
      .idx   (grant_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= arb_in & ~grant_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         post_valid <= 1'b0;
         post_cpu   <= '0;
         post_vec   <= '0;
      end else begin
         post_valid <= grant_any;
         post_cpu   <= cpu_arr[grant_idx];
         post_vec   <= vec_arr[grant_idx];
      end
   end

   always_comb begin
      rd_val = '0;
      case (acc_kind)
         ACC_ROUTE: begin
            rd_val[CPU_LSB +: CPU_W] = cpu_arr[acc_idx];
            rd_val[VEC_LSB +: VEC_W] = vec_arr[acc_idx];
         end
         ACC_CTRL: begin
            rd_val[MASK_BIT] = mask_vec[acc_idx];
            rd_val[PEND_BIT] = pend_vec[acc_idx];
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_ack   <= 1'b0;
         reg_err   <= 1'b0;
         reg_rdata <= '0;
      end else begin
         reg_ack   <= reg_req;
         reg_err   <= reg_req && (acc_kind == ACC_NONE);
         reg_rdata <= (reg_req && !reg_we) ? rd_val : '0;
      end
   end

   assert_ack_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_ack |-> $past(reg_req));

   assert_err_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_err |-> (reg_ack && (reg_rdata == '0)));

   assert_post_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      post_valid |-> $past(grant_any));

endmodule

// File: tb/tb_irq_route_ctrl.sv
module tb_irq_route_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NDEV = 32;
   localparam int AW   = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NDEV-1:0] dev_irq = '0;
   logic            reg_req = 1'b0;
   logic            reg_we = 1'b0;
   logic [AW-1:0]   reg_addr = '0;
   logic [63:0]     reg_wdata = '0;
   logic            reg_ack, reg_err, post_valid;
   logic [63:0]     reg_rdata;
   logic [4:0]      post_cpu;
   logic [5:0]      post_vec;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   irq_route_ctrl dut (
      .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq),
      .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_ack(reg_ack), .reg_rdata(reg_rdata), .reg_err(reg_err),
      .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // reference model state
   bit         m_mask [NDEV];
   bit         m_pend [NDEV];
   bit         m_req  [NDEV];
   logic [4:0] m_cpu  [NDEV];
   logic [5:0] m_vec  [NDEV];
   logic       e_ack, e_err, e_post;
   logic [63:0] e_rdata;
   logic [4:0] e_cpu;
   logic [5:0] e_vec;
   logic [10:0] post_log [$];

   function automatic logic m_hit(input logic [AW-1:0] a);
      return (a[2:0] == 3'b000) && (a[11:9] == 3'b000);
   endfunction

   always @(posedge clk) begin : model
      int g;
      bit cand [NDEV];
      logic [4:0] ix;
      if (!rst_n) begin
         for (int i = 0; i < NDEV; i++) begin
            m_mask[i] = 1'b1; m_pend[i] = 1'b0; m_req[i] = 1'b0;
            m_cpu[i] = '0;    m_vec[i] = '0;
         end
         e_ack = 0; e_err = 0; e_post = 0; e_rdata = '0; e_cpu = '0; e_vec = '0;
      end else begin
         ix      = reg_addr[7:3];
         e_ack   = reg_req;
         e_err   = reg_req && !m_hit(reg_addr);
         e_rdata = '0;
         if (reg_req && !reg_we && m_hit(reg_addr)) begin
            if (reg_addr[8]) e_rdata = {61'b0, m_mask[ix], 1'b0, m_pend[ix]};
            else             e_rdata = {51'b0, m_cpu[ix], 2'b0, m_vec[ix]};
         end
         g = -1;
         for (int i = 0; i < NDEV; i++) begin
            cand[i] = (m_req[i] || dev_irq[i]) && !m_mask[i];
            if (cand[i] && g < 0) g = i;
         end
         e_post = (g >= 0);
         if (g >= 0) begin e_cpu = m_cpu[g]; e_vec = m_vec[g]; end
         if (reg_req && reg_we && m_hit(reg_addr)) begin
            if (reg_addr[8]) begin
               m_mask[ix] = reg_wdata[2];
               if (reg_wdata[1]) m_pend[ix] = 1'b0;
            end else begin
               m_cpu[ix] = reg_wdata[12:8];
               m_vec[ix] = reg_wdata[5:0];
            end
         end
         if (g >= 0) begin m_mask[g] = 1'b1; m_pend[g] = 1'b1; end
         for (int i = 0; i < NDEV; i++) m_req[i] = cand[i] && (i != g);
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (post_valid) post_log.push_back({post_cpu, post_vec});
      chk(post_valid == e_post && (!e_post || {post_cpu, post_vec} == {e_cpu, e_vec}),
          "R6 post vs model", {52'b0, post_valid, post_cpu, post_vec}, {52'b0, e_post, e_cpu, e_vec});
      chk(reg_ack == e_ack && reg_err == e_err, "R10 ack/err vs model",
          {62'b0, reg_ack, reg_err}, {62'b0, e_ack, e_err});
      chk(reg_rdata == e_rdata, "R2 rdata vs model", reg_rdata, e_rdata);
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic bus(input logic we, input logic [AW-1:0] a, input logic [63:0] d,
                      input logic [NDEV-1:0] irq, output logic [63:0] rd, output logic er);
      step();
      reg_req = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d; dev_irq = irq;
      step();
      reg_req = 1'b0; reg_we = 1'b0; dev_irq = '0;
      rd = reg_rdata; er = reg_err;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
      logic [63:0] rd; logic er;
      bus(1'b1, a, d, '0, rd, er);
   endtask

   task automatic rd_chk(input logic [AW-1:0] a, input logic [63:0] exp, input bit exp_err, input string tag);
      logic [63:0] rd; logic er;
      bus(1'b0, a, 64'd0, '0, rd, er);
      chk(rd == exp && er == exp_err, tag, rd, exp);
   endtask

   task automatic fire(input logic [NDEV-1:0] irq);
      step();
      dev_irq = irq;
      step();
      dev_irq = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   function automatic logic [AW-1:0] route_a(input int i);
      return AW'(i * 8);
   endfunction
   function automatic logic [AW-1:0] ctrl_a(input int i);
      return AW'(256 + i * 8);
   endfunction

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         report();
         $finish;
      end
   end

   initial begin : stim
      logic [63:0] rd;
      logic er;
      repeat (3) @(negedge clk);
      chk(reg_ack == 0 && reg_err == 0 && post_valid == 0, "R1 outputs idle in reset",
          {61'b0, reg_ack, reg_err, post_valid}, 64'd0);
      rst_n = 1'b1;

      // R1: reset contents
      rd_chk(route_a(0), 64'd0, 0, "R1 route0 reset");
      rd_chk(route_a(31), 64'd0, 0, "R1 route31 reset");
      rd_chk(ctrl_a(5), 64'h4, 0, "R1 ctrl5 reset");
      rd_chk(ctrl_a(31), 64'h4, 0, "R1 ctrl31 reset");

      // R2: routing field isolation
      wr(route_a(3), 64'hFFFF_FFFF_FFFF_FFFF);
      rd_chk(route_a(3), 64'h1F3F, 0, "R2 route3 all-ones");
      wr(route_a(7), {51'b0, 5'd9, 2'b0, 6'h2A});
      rd_chk(route_a(7), 64'h092A, 0, "R2 route7");

      // R3: control readback after unmask
      wr(ctrl_a(3), 64'h0);
      rd_chk(ctrl_a(3), 64'h0, 0, "R3 ctrl3 unmasked");

      // R6: forward
      post_log.delete();
      fire(32'h8);
      idle(2);
      chk(post_log.size() == 1, "R6 one post", 64'(post_log.size()), 64'd1);
      if (post_log.size() > 0)
         chk(post_log[0] == {5'h1F, 6'h3F}, "R6 post fields", 64'(post_log[0]), 64'h7FF);
      rd_chk(ctrl_a(3), 64'h5, 0, "R6 auto mask and pend");

      // R5: masked arrival dropped
      post_log.delete();
      fire(32'h8);
      fire(32'h1);
      idle(2);
      chk(post_log.size() == 0, "R5 no post when masked", 64'(post_log.size()), 64'd0);
      rd_chk(ctrl_a(3), 64'h5, 0, "R5 ctrl3 unchanged");
      rd_chk(ctrl_a(0), 64'h4, 0, "R5 ctrl0 unchanged");

      // R4: clear-pending and no set-pending
      wr(ctrl_a(3), 64'h2);
      rd_chk(ctrl_a(3), 64'h0, 0, "R4 clear pend, unmask");
      wr(ctrl_a(3), 64'h7);
      rd_chk(ctrl_a(3), 64'h4, 0, "R4 write cannot set pend");
      wr(ctrl_a(3), 64'h1);
      rd_chk(ctrl_a(3), 64'h0, 0, "R4 bit0 write ignored");

      // R7: simultaneous firing, ascending order
      wr(route_a(10), {51'b0, 5'd3, 2'b0, 6'h11});
      wr(route_a(20), {51'b0, 5'h1E, 2'b0, 6'h05});
      wr(ctrl_a(7), 64'h0);
      wr(ctrl_a(10), 64'h0);
      wr(ctrl_a(20), 64'h0);
      post_log.delete();
      fire((32'd1 << 20) | (32'd1 << 10) | (32'd1 << 7));
      idle(4);
      chk(post_log.size() == 3, "R7 three posts", 64'(post_log.size()), 64'd3);
      if (post_log.size() == 3) begin
         chk(post_log[0] == {5'd9, 6'h2A}, "R7 first dev7", 64'(post_log[0]), 64'(11'({5'd9, 6'h2A})));
         chk(post_log[1] == {5'd3, 6'h11}, "R7 second dev10", 64'(post_log[1]), 64'(11'({5'd3, 6'h11})));
         chk(post_log[2] == {5'h1E, 6'h05}, "R7 third dev20", 64'(post_log[2]), 64'(11'({5'h1E, 6'h05})));
      end
      rd_chk(ctrl_a(20), 64'h5, 0, "R7 dev20 flags");

      // R8: held request masked before service
      wr(ctrl_a(1), 64'h0);
      wr(ctrl_a(2), 64'h0);
      post_log.delete();
      bus(1'b1, ctrl_a(2), 64'h4, 32'h6, rd, er);
      idle(3);
      chk(post_log.size() == 1, "R8 only dev1 posted", 64'(post_log.size()), 64'd1);
      rd_chk(ctrl_a(2), 64'h4, 0, "R8 dev2 dropped");
      rd_chk(ctrl_a(1), 64'h5, 0, "R8 dev1 forwarded");

      // R9: forward wins over same-cycle control write
      wr(ctrl_a(5), 64'h0);
      bus(1'b1, ctrl_a(5), 64'h2, 32'h20, rd, er);
      idle(1);
      rd_chk(ctrl_a(5), 64'h5, 0, "R9 forward beats write");

      // R10: unmapped accesses
      rd_chk(AW'(12'h104), 64'd0, 1, "R10 misaligned read");
      rd_chk(AW'(12'h200), 64'd0, 1, "R10 upper-bit read");
      wr(AW'(12'h200), 64'h0);
      rd_chk(ctrl_a(0), 64'h4, 0, "R10 unmapped write no effect");
      wr(AW'(12'h600), 64'hFFFF);
      rd_chk(route_a(0), 64'h0, 0, "R10 unmapped route write no effect");

      idle(2);
      done = 1'b1;
      report();
      $finish;
   end

endmodule